// File: doc/BRIEF.md
# Interleaved I/Q Sample Pairing Interface

This block accepts I and Q samples that share one narrow data bus and take turns on it. A steering input decides, write by write, whether the word on the bus lands in the I holding register or the Q holding register. A three-state controller counts writes in pairs. On the write that completes a pair, it copies both holding registers, including the word being written in that cycle, into a pair of output registers. It also raises a one-cycle strobe so that a downstream interpolator can take the aligned pair.

All logic runs on one clock. The write strobe is a synchronous enable sampled on the rising edge. A combined reset/sleep line works at the level of the pairing. While it is high at an edge, the controller returns to its idle state and ignores writes, and every register keeps its value. A single-cycle pulse restarts the pairing. Holding the line high puts the block to sleep. The pairing always assumes interleaved input: with the steering input held at one level, a pair still completes on every second write.

Top module: `iq_pair_if`

## Requirements
- R1: While rst_ni is low, i_o, q_o and both holding registers are 0, valid_o is 0, and the controller is idle, so the next write starts a new pair.
- R2: A write (we_i=1 at a rising edge with rs_i=0) stores data_i in the I holding register when sel_i=1 and in the Q holding register when sel_i=0. The data word is 10-bit unsigned binary, with bit 9 as the MSB.
- R3: Counting from the idle state, every second accepted write completes a pair. At the edge of that write, i_o and q_o take the current contents of the I and Q holding registers, including the word written at that same edge. valid_o is then 1 for exactly the following clock cycle.
- R4: A rising edge with we_i=0 and rs_i=0 leaves the pairing progress, both holding registers and both outputs unchanged, and valid_o is 0 after it.
- R5: At any rising edge with rs_i=1, the write is ignored, the holding registers and outputs keep their values, valid_o is 0 after the edge and the controller becomes idle. The first accepted write after rs_i falls starts a new pair.
- R6: With sel_i held at one level while writes repeat, a pair still completes on every second write. The register that was not written contributes its earlier value.
- R7: valid_o is never high in two consecutive cycles.
- R8: i_o and q_o change only at an edge that completes a pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rs_i | input | 1 | Combined pairing reset / sleep, synchronous, active high |
| we_i | input | 1 | Write enable, sampled on the rising edge |
| sel_i | input | 1 | Steering: 1 selects I, 0 selects Q |
| data_i | input | 10 | Sample word, unsigned binary |
| i_o | output | 10 | I sample of the last completed pair |
| q_o | output | 10 | Q sample of the last completed pair |
| valid_o | output | 1 | One-cycle strobe following each completed pair |

## Verification
The bench goes after pair alignment: a controller that committed on the first write, or that read the holding register before the completing write had landed, would present a stale or mismatched Q word. It pulses and holds rs_i between the two writes of a pair. A design that kept the half-finished pair would commit one write too early, and one that accepted writes while rs_i is high would change the outputs during sleep. Runs with the steering input held at one level, Q-first orderings and idle gaps expose designs that pair by select level instead of by write count, or that repeat the strobe. A long pseudo-random sweep, compared with an arithmetic model, also covers the all-zero and all-one codes.

// File: rtl/iq_pair_pkg.sv
package iq_pair_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HALF   = 2'd1,
    ST_COMMIT = 2'd2
  } pair_state_e;
endpackage

// File: rtl/iq_pair_fsm.sv
module iq_pair_fsm
  import iq_pair_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rs_i,
  input  logic we_i,
  output logic commit_o,
  output logic valid_o
);
  pair_state_e state_q, state_d;
  logic        valid_q;

  always_comb begin
    state_d = state_q;
    if (rs_i) begin
      state_d = ST_IDLE;
    end else if (we_i) begin
      case (state_q)
        ST_HALF: state_d = ST_COMMIT;
        default: state_d = ST_HALF;
      endcase
    end
  end

  assign commit_o = !rs_i && we_i && (state_q == ST_HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= commit_o;
    end
  end

  assign valid_o = valid_q;

  p_valid_in_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (state_q == ST_COMMIT));
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rs_i && !we_i) |=> $stable(state_q));
  p_rs_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_i |=> (state_q == ST_IDLE && !valid_o));
  p_valid_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/iq_hold_regs.sv
module iq_hold_regs #(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rs_i,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] i_reg_o,
  output logic [DW-1:0] q_reg_o
);
  localparam int NCH = 2;
  logic [NCH-1:0][DW-1:0] hold_q;

  // channel 0 = I (sel high), channel 1 = Q (sel low)
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = !rs_i && we_i && ((ch == 0) ? sel_i : !sel_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  hold_q[ch] <= '0;
      else if (hit) hold_q[ch] <= data_i;
    end
  end

  assign i_reg_o = hold_q[0];
  assign q_reg_o = hold_q[1];

  p_i_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i && !rs_i) |=> (i_reg_o == $past(data_i)));
  p_q_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_i && !rs_i) |=> (q_reg_o == $past(data_i)));
  p_sleep_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_i |=> ($stable(i_reg_o) && $stable(q_reg_o)));
endmodule

// File: rtl/iq_out_regs.sv
module iq_out_regs #(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] i_reg_i,
  input  logic [DW-1:0] q_reg_i,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] i_nx, q_nx;

  // completing write is forwarded so the pair holds it at the same edge
  assign i_nx = (we_i && sel_i)  ? data_i : i_reg_i;
  assign q_nx = (we_i && !sel_i) ? data_i : q_reg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o <= '0;
      q_o <= '0;
    end else if (commit_i) begin
      i_o <= i_nx;
      q_o <= q_nx;
    end
  end

  p_out_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(i_o) && $stable(q_o)));
endmodule

// File: rtl/iq_pair_if.sv
module iq_pair_if #(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rs_i,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o,
  output logic          valid_o
);
  logic          commit;
  logic [DW-1:0] i_reg, q_reg;

  iq_pair_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rs_i     (rs_i),
    .we_i     (we_i),
    .commit_o (commit),
    .valid_o  (valid_o)
  );

  iq_hold_regs #(.DW(DW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rs_i    (rs_i),
    .we_i    (we_i),
    .sel_i   (sel_i),
    .data_i  (data_i),
    .i_reg_o (i_reg),
    .q_reg_o (q_reg)
  );

  iq_out_regs #(.DW(DW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .we_i     (we_i),
    .sel_i    (sel_i),
    .data_i   (data_i),
    .i_reg_i  (i_reg),
    .q_reg_i  (q_reg),
    .i_o      (i_o),
    .q_o      (q_o)
  );

  p_rst_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (i_o == '0 && q_o == '0 && !valid_o));
endmodule

// File: tb/iq_pair_if_tb.sv
module iq_pair_if_tb;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rs_i = 1'b0, we_i = 1'b0, sel_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] i_o, q_o;
  logic          valid_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  logic [DW-1:0] m_i = '0, m_q = '0, e_i = '0, e_q = '0;
  bit m_pend = 1'b0, e_v = 1'b0, prev_v = 1'b0;

  always #10 clk = ~clk;

  iq_pair_if #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rs_i(rs_i), .we_i(we_i), .sel_i(sel_i),
    .data_i(data_i), .i_o(i_o), .q_o(q_o), .valid_o(valid_o)
  );

  task automatic check(input string tag);
    checks++;
    if (i_o !== e_i || q_o !== e_q || valid_o !== e_v) begin
      errors++;
      $display("FAIL %s: i=%h q=%h v=%b expected i=%h q=%h v=%b",
               tag, i_o, q_o, valid_o, e_i, e_q, e_v);
    end
  endtask

  task automatic step(input bit w, input bit s, input logic [DW-1:0] d,
                      input bit r, input string tag);
    we_i = w; sel_i = s; data_i = d; rs_i = r;
    @(posedge clk);
    if (r) begin
      m_pend = 1'b0; e_v = 1'b0;
    end else if (w) begin
      if (s) m_i = d; else m_q = d;
      if (m_pend) begin
        e_i = m_i; e_q = m_q; e_v = 1'b1; m_pend = 1'b0;
      end else begin
        m_pend = 1'b1; e_v = 1'b0;
      end
    end else begin
      e_v = 1'b0;
    end
    @(negedge clk);
    check(tag);
    checks++;
    if (prev_v && valid_o) begin
      errors++;
      $display("FAIL R7: valid high twice, actual=1 expected=0");
    end
    prev_v = valid_o;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1");

    // R3: basic I then Q
    step(1, 1, 10'h155, 0, "R3");
    step(1, 0, 10'h2AA, 0, "R3");
    // R4: idle edges
    step(0, 1, 10'h3FF, 0, "R4");
    step(0, 0, 10'h000, 0, "R4");
    // R2: Q first then I
    step(1, 0, 10'h0F0, 0, "R2");
    step(0, 0, 10'h111, 0, "R4");
    step(1, 1, 10'h30F, 0, "R2");
    // R5: pulse mid-pair discards half pair, write during rs ignored
    step(1, 1, 10'h001, 0, "R5");
    step(1, 0, 10'h222, 1, "R5");
    step(1, 0, 10'h0AA, 0, "R5");
    step(1, 1, 10'h3FF, 0, "R5");
    // R5: sleep held with writes
    for (int k = 0; k < 5; k++) step(1, k[0], 10'(k * 77), 1, "R5");
    step(1, 1, 10'h000, 0, "R5");
    step(1, 0, 10'h3FF, 0, "R5");
    // R6: constant select
    for (int k = 0; k < 6; k++) step(1, 1, 10'(k * 101 + 3), 0, "R6");
    for (int k = 0; k < 6; k++) step(1, 0, 10'(k * 53 + 9), 0, "R6");
    // R8: pseudo-random sweep
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[2], (lfsr[5:3] == 3'd0) ? '0 :
           (lfsr[5:3] == 3'd7) ? '1 : lfsr[15:6], (lfsr[11:7] == 5'd0), "R8");
    end
    // R1: async reset mid-pair
    step(1, 1, 10'h123, 0, "R1");
    rst_ni = 1'b0;
    m_i = '0; m_q = '0; e_i = '0; e_q = '0; e_v = 1'b0; m_pend = 1'b0;
    #1;
    check("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    step(1, 0, 10'h045, 0, "R1");
    step(1, 1, 10'h046, 0, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule